// File: doc/BRIEF.md
# DS3 Out-of-Frame Supervisor

This block guards frame alignment on a received DS3 stream once the upstream hunter has found it. It does not see the raw bit stream. It only receives event strobes from the alignment logic: an F-bit position reached, an M-bit position reached, and the end of an M-frame. Each strobe carries its own error flag. Three run-time selects choose the loss criteria. These are a strict or lenient F-bit threshold, whether M-bit errors count at all, and whether parity errors count as a framing criterion. Any criterion that reaches its threshold drops the block out of frame.

When the block goes out of frame, it raises a registered out-of-frame status and sends a one-cycle reframe request to the hunter. It then waits for the hunter to report a qualified alignment. With parity framing selected, the next M-frame must also pass its parity check before the block returns to in-frame.

Top module: `ds3_oof_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `oofStatus` reads 1 and `reframeReq` reads 0 until the block first reaches in-frame.
- R2: While in frame, each `fBitValid` strobe appends `fBitErr` to a 16-entry F history. With `fThreshSel`=1, 3 errors in that history declare out-of-frame. With `fThreshSel`=0, 6 errors are needed.
- R3: With `mCheckEn`=1, 3 errors among the last 4 `mBitValid` strobes declare out-of-frame. With `mCheckEn`=0, M-bit errors never cause out-of-frame.
- R4: With `parityFrameEn`=1, parity errors on 2 of the last 5 `frameEnd` strobes declare out-of-frame. With `parityFrameEn`=0, parity errors never cause it.
- R5: `oofStatus` rises at the clock edge that samples the tripping strobe. `reframeReq` is high for exactly that one following cycle.
- R6: A history moves only on its own strobe. Errors older than the window length, counted in strobes, no longer count.
- R7: On entering out-of-frame, all histories are cleared. Strobes received while out of frame are not recorded.
- R8: While out of frame with `parityFrameEn`=0, an `acqQualify` pulse clears `oofStatus` at the next clock edge.
- R9: While out of frame with `parityFrameEn`=1, an `acqQualify` pulse arms a parity wait. The next `frameEnd` arriving in a later cycle with `parityErr`=0 clears `oofStatus`. If that `frameEnd` has `parityErr`=1, the block returns to waiting for `acqQualify`.
- R10: Changing a select does not clear any history. The new threshold applies at the next strobe of that history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fBitValid | input | 1 | F-bit position strobe |
| fBitErr | input | 1 | F-bit value wrong (with fBitValid) |
| mBitValid | input | 1 | M-bit position strobe |
| mBitErr | input | 1 | M-bit value wrong (with mBitValid) |
| frameEnd | input | 1 | End of M-frame strobe |
| parityErr | input | 1 | Parity mismatch for that M-frame (with frameEnd) |
| fThreshSel | input | 1 | 1: 3-of-16 F rule, 0: 6-of-16 |
| mCheckEn | input | 1 | 1: apply 3-of-4 M rule |
| parityFrameEn | input | 1 | 1: apply 2-of-5 parity rule and parity gate on acquisition |
| acqQualify | input | 1 | Hunter reports alignment found |
| oofStatus | output | 1 | 1 while out of frame |
| reframeReq | output | 1 | One-cycle request to restart the frame hunt |

## Verification
Every result of this block appears one clock edge after the input that causes it. A tripping strobe, an `acqQualify` pulse and a clean `frameEnd` in the parity wait all take effect at that edge, and `reframeReq` drops again one edge after it rises. The bench drives each stimulus at a falling edge. It steps its own model once and compares both outputs at the next falling edge, so every comparison falls exactly one register stage after its cause. Directed runs place errors at the threshold, one below it, and just outside the window. A long random run mixes strobes, acquisition pulses and select changes.

// File: rtl/oofmon_pkg.sv
package oofmon_pkg;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_PWAIT = 2'd1,
    ST_SYNC  = 2'd2
  } syncState_t;

  // control -> datapath
  typedef struct packed {
    logic histShift;
    logic histClear;
  } histCtl_t;

  // datapath -> control
  typedef struct packed {
    logic fTrip;
    logic mTrip;
    logic pTrip;
  } tripFlags_t;

endpackage

// File: rtl/oofmon_window.sv
module oofmon_window #(
  parameter int LEN = 16,
  localparam int CW = $clog2(LEN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          shiftEn,
  input  logic          clear,
  input  logic          valid,
  input  logic          err,
  output logic [CW-1:0] nextCount,
  output logic          updated
);

  logic [LEN-1:0] hist;
  logic [LEN-1:0] histNext;

  assign updated  = valid & shiftEn;
  assign histNext = {hist[LEN-2:0], err};

  always_comb begin
    nextCount = '0;
    for (int i = 0; i < LEN; i++) begin
      nextCount = nextCount + CW'(histNext[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
    end else if (clear) begin
      hist <= '0;
    end else if (updated) begin
      hist <= histNext;
    end
  end

endmodule

// File: rtl/oofmon_datapath.sv
module oofmon_datapath
  import oofmon_pkg::*;
#(
  parameter int F_LEN        = 16,
  parameter int F_THR_STRICT = 3,
  parameter int F_THR_LOOSE  = 6,
  parameter int M_LEN        = 4,
  parameter int M_THR        = 3,
  parameter int P_LEN        = 5,
  parameter int P_THR        = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  histCtl_t   ctl,
  input  logic       fBitValid,
  input  logic       fBitErr,
  input  logic       mBitValid,
  input  logic       mBitErr,
  input  logic       frameEnd,
  input  logic       parityErr,
  input  logic       fThreshSel,
  input  logic       mCheckEn,
  input  logic       parityFrameEn,
  output tripFlags_t trips
);

  localparam int FCW = $clog2(F_LEN + 1);
  localparam int MCW = $clog2(M_LEN + 1);
  localparam int PCW = $clog2(P_LEN + 1);
  localparam logic [FCW-1:0] F_STRICT_W = FCW'(F_THR_STRICT);
  localparam logic [FCW-1:0] F_LOOSE_W  = FCW'(F_THR_LOOSE);
  localparam logic [MCW-1:0] M_THR_W    = MCW'(M_THR);
  localparam logic [PCW-1:0] P_THR_W    = PCW'(P_THR);

  logic [FCW-1:0] fCount;
  logic [MCW-1:0] mCount;
  logic [PCW-1:0] pCount;
  logic fUpd, mUpd, pUpd;
  logic [FCW-1:0] fLimit;

  oofmon_window #(.LEN(F_LEN)) i_fWin (
    .clk(clk), .rstN(rstN), .shiftEn(ctl.histShift), .clear(ctl.histClear),
    .valid(fBitValid), .err(fBitErr), .nextCount(fCount), .updated(fUpd)
  );

  oofmon_window #(.LEN(M_LEN)) i_mWin (
    .clk(clk), .rstN(rstN), .shiftEn(ctl.histShift), .clear(ctl.histClear),
    .valid(mBitValid), .err(mBitErr), .nextCount(mCount), .updated(mUpd)
  );

  oofmon_window #(.LEN(P_LEN)) i_pWin (
    .clk(clk), .rstN(rstN), .shiftEn(ctl.histShift), .clear(ctl.histClear),
    .valid(frameEnd), .err(parityErr), .nextCount(pCount), .updated(pUpd)
  );

  assign fLimit = fThreshSel ? F_STRICT_W : F_LOOSE_W;

  always_comb begin
    trips.fTrip = fUpd && (fCount >= fLimit);
    trips.mTrip = mUpd && mCheckEn && (mCount >= M_THR_W);
    trips.pTrip = pUpd && parityFrameEn && (pCount >= P_THR_W);
  end

endmodule

// File: rtl/oofmon_control.sv
module oofmon_control
  import oofmon_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  tripFlags_t trips,
  input  logic       acqQualify,
  input  logic       frameEnd,
  input  logic       parityErr,
  input  logic       parityFrameEn,
  output histCtl_t   ctl,
  output logic       oofQ,
  output logic       reframeQ
);

  syncState_t state, stateNext;
  logic tripAny;

  assign tripAny = (state == ST_SYNC) && (|trips);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_SYNC:  if (tripAny) stateNext = ST_HUNT;
      ST_HUNT:  if (acqQualify) stateNext = parityFrameEn ? ST_PWAIT : ST_SYNC;
      ST_PWAIT: if (frameEnd) stateNext = parityErr ? ST_HUNT : ST_SYNC;
      default:  stateNext = ST_HUNT;
    endcase
  end

  always_comb begin
    ctl.histShift = (state == ST_SYNC);
    ctl.histClear = (state != ST_SYNC) || tripAny;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      oofQ     <= 1'b1;
      reframeQ <= 1'b0;
    end else begin
      state    <= stateNext;
      oofQ     <= (stateNext != ST_SYNC);
      reframeQ <= tripAny;
    end
  end

endmodule

// File: rtl/ds3_oof_monitor.sv
module ds3_oof_monitor
  import oofmon_pkg::*;
#(
  parameter int F_LEN        = 16,
  parameter int F_THR_STRICT = 3,
  parameter int F_THR_LOOSE  = 6,
  parameter int M_LEN        = 4,
  parameter int M_THR        = 3,
  parameter int P_LEN        = 5,
  parameter int P_THR        = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic fBitValid,
  input  logic fBitErr,
  input  logic mBitValid,
  input  logic mBitErr,
  input  logic frameEnd,
  input  logic parityErr,
  input  logic fThreshSel,
  input  logic mCheckEn,
  input  logic parityFrameEn,
  input  logic acqQualify,
  output logic oofStatus,
  output logic reframeReq
);

  histCtl_t   ctl;
  tripFlags_t trips;

  oofmon_datapath #(
    .F_LEN(F_LEN), .F_THR_STRICT(F_THR_STRICT), .F_THR_LOOSE(F_THR_LOOSE),
    .M_LEN(M_LEN), .M_THR(M_THR), .P_LEN(P_LEN), .P_THR(P_THR)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .fBitValid(fBitValid), .fBitErr(fBitErr),
    .mBitValid(mBitValid), .mBitErr(mBitErr),
    .frameEnd(frameEnd), .parityErr(parityErr),
    .fThreshSel(fThreshSel), .mCheckEn(mCheckEn),
    .parityFrameEn(parityFrameEn), .trips(trips)
  );

  oofmon_control i_control (
    .clk(clk), .rstN(rstN), .trips(trips),
    .acqQualify(acqQualify), .frameEnd(frameEnd), .parityErr(parityErr),
    .parityFrameEn(parityFrameEn), .ctl(ctl),
    .oofQ(oofStatus), .reframeQ(reframeReq)
  );

endmodule

// File: rtl/oofmon_checker.sv
module oofmon_checker (
  input logic clk,
  input logic rstN,
  input logic fBitValid,
  input logic mBitValid,
  input logic frameEnd,
  input logic parityErr,
  input logic mCheckEn,
  input logic acqQualify,
  input logic oofStatus,
  input logic reframeReq
);

  AST_RESET_OOF: assert property (@(posedge clk) !rstN |=> oofStatus && !reframeReq); // R1

  AST_REFRAME_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    reframeReq |-> oofStatus && !$past(oofStatus)); // R5

  AST_REFRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    reframeReq |=> !reframeReq); // R5

  AST_M_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !oofStatus && !fBitValid && !frameEnd && !mCheckEn |=> !oofStatus); // R3

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !oofStatus && !fBitValid && !mBitValid && !frameEnd |=> !oofStatus); // R6

  AST_STAY_OOF: assert property (@(posedge clk) disable iff (!rstN)
    oofStatus && !acqQualify && !frameEnd |=> oofStatus); // R8

  AST_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oofStatus) |-> $past(acqQualify) || ($past(frameEnd) && !$past(parityErr))); // R9

endmodule

bind ds3_oof_monitor oofmon_checker i_oofmon_checker (
  .clk(clk), .rstN(rstN), .fBitValid(fBitValid), .mBitValid(mBitValid),
  .frameEnd(frameEnd), .parityErr(parityErr), .mCheckEn(mCheckEn),
  .acqQualify(acqQualify), .oofStatus(oofStatus), .reframeReq(reframeReq)
);

// File: tb/test_ds3_oof_monitor.sv
`timescale 1ns/1ps
module test_ds3_oof_monitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fBitValid = 0, fBitErr = 0, mBitValid = 0, mBitErr = 0;
  logic frameEnd = 0, parityErr = 0, acqQualify = 0;
  logic fThreshSel = 1, mCheckEn = 0, parityFrameEn = 0;
  logic oofStatus, reframeReq;

  int checks = 0;
  int errors = 0;

  // reference model state: 0 hunt, 1 parity wait, 2 in frame
  int mdlState = 0;
  logic [15:0] mdlF = '0;
  logic [3:0]  mdlM = '0;
  logic [4:0]  mdlP = '0;
  logic expOof = 1'b1;
  logic expRef = 1'b0;

  always #10 clk = ~clk;

  ds3_oof_monitor i_ds3_oof_monitor (
    .clk(clk), .rstN(rstN),
    .fBitValid(fBitValid), .fBitErr(fBitErr),
    .mBitValid(mBitValid), .mBitErr(mBitErr),
    .frameEnd(frameEnd), .parityErr(parityErr),
    .fThreshSel(fThreshSel), .mCheckEn(mCheckEn),
    .parityFrameEn(parityFrameEn), .acqQualify(acqQualify),
    .oofStatus(oofStatus), .reframeReq(reframeReq)
  );

  function automatic int ones(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic modelStep();
    logic [15:0] nf;
    logic [3:0] nm;
    logic [4:0] np;
    logic trip;
    expRef = 1'b0;
    if (mdlState == 2) begin
      nf = fBitValid ? {mdlF[14:0], fBitErr} : mdlF;
      nm = mBitValid ? {mdlM[2:0], mBitErr} : mdlM;
      np = frameEnd ? {mdlP[3:0], parityErr} : mdlP;
      trip = (fBitValid && ones(nf) >= (fThreshSel ? 3 : 6))
          || (mBitValid && mCheckEn && ones({12'd0, nm}) >= 3)
          || (frameEnd && parityFrameEn && ones({11'd0, np}) >= 2);
      if (trip) begin
        mdlState = 0; mdlF = '0; mdlM = '0; mdlP = '0; expRef = 1'b1;
      end else begin
        mdlF = nf; mdlM = nm; mdlP = np;
      end
    end else if (mdlState == 0) begin
      if (acqQualify) mdlState = parityFrameEn ? 1 : 2;
    end else begin
      if (frameEnd) mdlState = parityErr ? 0 : 2;
    end
    expOof = (mdlState != 2);
  endtask

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // drive one cycle at a falling edge, compare at the next falling edge
  task automatic cyc(input logic fv, input logic fe, input logic mv, input logic me,
                     input logic pv, input logic pe, input logic aq, input string req);
    fBitValid = fv; fBitErr = fe; mBitValid = mv; mBitErr = me;
    frameEnd = pv; parityErr = pe; acqQualify = aq;
    modelStep();
    @(posedge clk);
    @(negedge clk);
    check(req, oofStatus, expOof, "oofStatus");
    check(req, reframeReq, expRef, "reframeReq");
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,"R6"); endtask
  task automatic fEv(input logic e, input string req); cyc(1,e,0,0,0,0,0,req); endtask
  task automatic mEv(input logic e, input string req); cyc(0,0,1,e,0,0,0,req); endtask
  task automatic pEv(input logic e, input string req); cyc(0,0,0,0,1,e,0,req); endtask

  task automatic goSync();
    cyc(0,0,0,0,0,0,1,"R8");
    if (parityFrameEn) pEv(1'b0, "R9");
    check("R8", oofStatus, 1'b0, "in frame after acquisition");
  endtask

  task automatic forceOof();
    fThreshSel = 1;
    repeat (3) fEv(1'b1, "R2");
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", oofStatus, 1'b1, "oof during reset");
    check("R1", reframeReq, 1'b0, "reframe during reset");
    rstN = 1'b1;
    idle(); idle();
    check("R1", oofStatus, 1'b1, "oof after reset");

    // R2 strict rule, R5 timing
    fThreshSel = 1; mCheckEn = 0; parityFrameEn = 0;
    goSync();
    fEv(1, "R2"); fEv(0, "R2"); fEv(1, "R2");
    check("R2", oofStatus, 1'b0, "two F errors");
    fEv(1, "R5");
    check("R5", oofStatus, 1'b1, "third F error trips");
    check("R5", reframeReq, 1'b1, "reframe pulse");
    idle();
    check("R5", reframeReq, 1'b0, "reframe drops");

    // R7 strobes while OOF ignored, history cleared
    repeat (5) fEv(1, "R7");
    goSync();
    fEv(1, "R7"); fEv(1, "R7");
    check("R7", oofStatus, 1'b0, "history cleared");
    fEv(1, "R7");

    // R2 lenient rule
    fThreshSel = 0;
    goSync();
    repeat (5) fEv(1, "R2");
    check("R2", oofStatus, 1'b0, "five F errors lenient");
    fEv(1, "R2");
    check("R2", oofStatus, 1'b1, "sixth F error trips");

    // R6 window slide
    fThreshSel = 1;
    goSync();
    fEv(1, "R6");
    repeat (16) fEv(0, "R6");
    fEv(1, "R6"); idle(); fEv(1, "R6");
    check("R6", oofStatus, 1'b0, "aged error dropped");
    fEv(1, "R6");
    check("R6", oofStatus, 1'b1, "three in window");

    // R3 disabled, then R10 enabling keeps history
    mCheckEn = 0;
    goSync();
    repeat (4) mEv(1, "R3");
    check("R3", oofStatus, 1'b0, "M ignored");
    @(negedge clk); mCheckEn = 1;
    mEv(0, "R10");
    check("R10", oofStatus, 1'b1, "select change keeps history");
    goSync();
    mEv(1, "R3"); mEv(1, "R3");
    check("R3", oofStatus, 1'b0, "two M errors");
    mEv(1, "R3");
    check("R3", oofStatus, 1'b1, "three of four M");
    mCheckEn = 0;

    // R4 waived then enabled
    parityFrameEn = 0;
    goSync();
    repeat (3) pEv(1, "R4");
    check("R4", oofStatus, 1'b0, "parity waived");
    forceOof();
    parityFrameEn = 1;
    goSync();
    pEv(1, "R4");
    repeat (4) pEv(0, "R4");
    pEv(1, "R4");
    check("R4", oofStatus, 1'b0, "parity error aged out");
    pEv(1, "R4");
    check("R4", oofStatus, 1'b1, "two of five parity");

    // R9 parity gate on acquisition
    cyc(0,0,0,0,0,0,1,"R9");
    check("R9", oofStatus, 1'b1, "waiting parity");
    pEv(1, "R9");
    check("R9", oofStatus, 1'b1, "bad parity back to hunt");
    pEv(0, "R9");
    check("R9", oofStatus, 1'b1, "needs new qualify");
    cyc(0,0,0,0,1,0,1,"R9");
    check("R9", oofStatus, 1'b1, "same-cycle frameEnd not counted");
    pEv(0, "R9");
    check("R9", oofStatus, 1'b0, "clean parity gives in frame");
    parityFrameEn = 0;
    forceOof();
    cyc(0,0,0,0,0,0,1,"R8");
    check("R8", oofStatus, 1'b0, "acq without parity");

    // constrained random
    void'($urandom(32'h5eed_0d53));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 199) == 0) fThreshSel = 1'($urandom);
      if ($urandom_range(0, 199) == 0) mCheckEn = 1'($urandom);
      if ($urandom_range(0, 199) == 0) parityFrameEn = 1'($urandom);
      cyc($urandom_range(0,3) == 0, $urandom_range(0,9) == 0,
          $urandom_range(0,5) == 0, $urandom_range(0,4) == 0,
          $urandom_range(0,7) == 0, $urandom_range(0,5) == 0,
          $urandom_range(0,15) == 0, "R2");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule